// File: doc/BRIEF.md
# Doppler Power Spectrum Range Averager

This block sits behind a 64-point Doppler FFT in a radar spectral pipeline. It receives the complex FFT bins of one range cell after another. Each bin is a signed 16-bit real/imaginary pair, tagged with its Doppler index, and the final bin of each range cell is flagged. For every bin the block forms the power, re² + im², and adds it to a per-Doppler-bin accumulator. It combines eight consecutive range cells this way, so 30 m cells become about 240 m cells.

After the eighth range cell it streams the 64 averaged powers out in Doppler-index order, with a flag on the last one. Over a 480-cell block that yields 60 spectra, and the output rate falls well below the input rate.

While the averaged spectrum is being drained, the input side is stalled. A stalled downstream therefore can never lose or overwrite accumulated data. A synchronous block-start pulse realigns the eight-cell grouping to the start of a new block.

Top module: `doppler_range_avg`

## Requirements
- R1: The power of an accepted bin is re² + im², with both parts taken as two's-complement signed values. Both parts at -32768 give 2^31.
- R2: Output value k is floor(S_k / 8) truncated to 32 bits. S_k is the sum of the eight powers received at Doppler index k during the group. The output never exceeds 2^31.
- R3: The first range cell of each group replaces the stored accumulator values rather than adding to them, so nothing from an earlier group leaks into a later one.
- R4: A range cell ends with an accepted beat that has `in_last_i` high. After the eighth such cell, 64 output beats follow with `out_idx_o` counting from 0 up to 63. After the last beat the block accepts input again.
- R5: `out_done_o` is high only on the output beat with index 63.
- R6: While output beats are pending, `in_ready_o` is low. A beat held by `out_ready_i` low keeps its index and value until it is taken.
- R7: A cycle with `blk_start_i` high resets the range-cell count. Partial sums are then discarded, and the next range cell starts a new group. A drain in progress is abandoned: the next cycle shows `out_valid_o` low and `in_ready_o` high.
- R8: After reset, `out_valid_o` and `out_done_o` are low and `in_ready_o` is high.
- R9: A cycle with `in_valid_i` low changes no sum and no count, whatever data or last flag it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_start_i | input | 1 | Synchronous block-start pulse |
| in_valid_i | input | 1 | Input bin valid |
| in_ready_o | output | 1 | Input bin accepted when high with valid |
| in_re_i | input | 16 | Real part, signed |
| in_im_i | input | 16 | Imaginary part, signed |
| in_idx_i | input | 6 | Doppler bin index |
| in_last_i | input | 1 | Final bin of the current range cell |
| out_valid_o | output | 1 | Averaged power valid |
| out_ready_i | input | 1 | Downstream accepts the output beat |
| out_pwr_o | output | 32 | Averaged power |
| out_idx_o | output | 6 | Doppler index of the output beat |
| out_done_o | output | 1 | Last beat of the averaged spectrum |

## Verification
Errors in the accumulator bank show up only at the next drain, eight range cells later, as wrong values at specific indices. For that reason every group is checked on all 64 beats, and groups run back to back so a missed load shows up as stale data. A range count that is off shows up on the next drain as a drain that arrives early or late, which misaligns every later group. Stalls are checked directly at the ports: held beats must keep their value, and input must stay blocked.

// File: rtl/dra_pkg.sv
package dra_pkg;
  typedef enum logic {
    ST_ACCUM = 1'b0,
    ST_DUMP  = 1'b1
  } dra_state_e;
endpackage

// File: rtl/dra_power_sq.sv
module dra_power_sq #(
  parameter int IN_W  = 16,
  parameter int PWR_W = 2 * IN_W + 1
) (
  input  logic signed [IN_W-1:0] re_i,
  input  logic signed [IN_W-1:0] im_i,
  output logic [PWR_W-1:0]       pwr_o
);
  logic signed [2*IN_W-1:0] sq_re, sq_im;

  always_comb begin
    sq_re = re_i * re_i;
    sq_im = im_i * im_i;
    // squares are non-negative, so zero extension is exact
    pwr_o = PWR_W'($unsigned(sq_re)) + PWR_W'($unsigned(sq_im));
  end
endmodule

// File: rtl/dra_acc_bank.sv
module dra_acc_bank #(
  parameter int DEPTH = 64,
  parameter int PWR_W = 33,
  parameter int ACC_W = 36,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             load_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PWR_W-1:0] pwr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [ACC_W-1:0] rd_data_o
);
  logic [ACC_W-1:0] acc_q [DEPTH];
  logic [ACC_W-1:0] pwr_ext;

  assign pwr_ext = ACC_W'(pwr_i);

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        acc_q[g] <= load_i ? pwr_ext : acc_q[g] + pwr_ext;
      end
    end
  end

  assign rd_data_o = acc_q[rd_idx_i];
endmodule

// File: rtl/dra_group_ctrl.sv
module dra_group_ctrl
  import dra_pkg::*;
#(
  parameter int GROUP = 8,
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(GROUP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             blk_start_i,
  input  logic             sample_fire_i,
  input  logic             last_i,
  input  logic             dump_fire_i,
  output logic             first_o,
  output logic             dumping_o,
  output logic [IDX_W-1:0] dump_idx_o
);
  dra_state_e       state_q;
  logic [CNT_W-1:0] range_q;
  logic [IDX_W-1:0] dump_q;

  // block start makes the current cycle the start of a group
  assign first_o    = blk_start_i || (range_q == '0);
  assign dumping_o  = (state_q == ST_DUMP);
  assign dump_idx_o = dump_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACCUM;
      range_q <= '0;
      dump_q  <= '0;
    end else if (blk_start_i) begin
      state_q <= ST_ACCUM;
      dump_q  <= '0;
      range_q <= (sample_fire_i && last_i) ? CNT_W'(1) : '0;
    end else begin
      unique case (state_q)
        ST_ACCUM: begin
          if (sample_fire_i && last_i) begin
            if (range_q == CNT_W'(GROUP - 1)) begin
              range_q <= '0;
              dump_q  <= '0;
              state_q <= ST_DUMP;
            end else begin
              range_q <= range_q + CNT_W'(1);
            end
          end
        end
        ST_DUMP: begin
          if (dump_fire_i) begin
            if (dump_q == IDX_W'(DEPTH - 1)) begin
              dump_q  <= '0;
              state_q <= ST_ACCUM;
            end else begin
              dump_q <= dump_q + IDX_W'(1);
            end
          end
        end
        default: state_q <= ST_ACCUM;
      endcase
    end
  end
endmodule

// File: rtl/doppler_range_avg.sv
module doppler_range_avg #(
  parameter int IN_W  = 16,
  parameter int DEPTH = 64,
  parameter int GROUP = 8,
  parameter int OUT_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          blk_start_i,
  input  logic                          in_valid_i,
  output logic                          in_ready_o,
  input  logic signed [IN_W-1:0]        in_re_i,
  input  logic signed [IN_W-1:0]        in_im_i,
  input  logic [$clog2(DEPTH)-1:0]      in_idx_i,
  input  logic                          in_last_i,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [OUT_W-1:0]              out_pwr_o,
  output logic [$clog2(DEPTH)-1:0]      out_idx_o,
  output logic                          out_done_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int SHIFT = $clog2(GROUP);
  localparam int PWR_W = 2 * IN_W + 1;
  localparam int ACC_W = PWR_W + SHIFT;

  logic             sample_fire, dump_fire, first, dumping;
  logic [IDX_W-1:0] dump_idx;
  logic [PWR_W-1:0] pwr;
  logic [ACC_W-1:0] rd_data;

  assign in_ready_o  = !dumping;
  assign sample_fire = in_valid_i && in_ready_o;
  assign out_valid_o = dumping;
  assign dump_fire   = out_valid_o && out_ready_i;
  assign out_idx_o   = dump_idx;
  assign out_done_o  = dumping && (dump_idx == IDX_W'(DEPTH - 1));
  assign out_pwr_o   = OUT_W'(rd_data >> SHIFT);

  dra_power_sq #(.IN_W(IN_W), .PWR_W(PWR_W)) u_sq (
    .re_i  (in_re_i),
    .im_i  (in_im_i),
    .pwr_o (pwr)
  );

  dra_acc_bank #(.DEPTH(DEPTH), .PWR_W(PWR_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (sample_fire),
    .load_i    (first),
    .wr_idx_i  (in_idx_i),
    .pwr_i     (pwr),
    .rd_idx_i  (dump_idx),
    .rd_data_o (rd_data)
  );

  dra_group_ctrl #(.GROUP(GROUP), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .blk_start_i   (blk_start_i),
    .sample_fire_i (sample_fire),
    .last_i        (in_last_i),
    .dump_fire_i   (dump_fire),
    .first_o       (first),
    .dumping_o     (dumping),
    .dump_idx_o    (dump_idx)
  );
endmodule

// File: rtl/dra_checker.sv
module dra_checker #(
  parameter int IN_W  = 16,
  parameter int IDX_W = 6,
  parameter int OUT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             blk_start_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [OUT_W-1:0] out_pwr_o,
  input logic [IDX_W-1:0] out_idx_o,
  input logic             out_done_o
);
  localparam logic [OUT_W-1:0] PMAX = OUT_W'(1) << (2 * IN_W - 1);

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_pwr_o <= PMAX));

  assert_first_beat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> (out_idx_o == '0));

  assert_beat_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !out_done_o && !blk_start_i)
      |=> (out_valid_o && out_idx_o == $past(out_idx_o) + IDX_W'(1)));

  assert_done_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_done_o |-> (out_valid_o && out_idx_o == '1));

  assert_input_blocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  assert_hold_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !blk_start_i)
      |=> (out_valid_o && $stable(out_idx_o) && $stable(out_pwr_o)));

  assert_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_start_i |=> (!out_valid_o && in_ready_o));
endmodule

bind doppler_range_avg dra_checker #(.IN_W(IN_W), .IDX_W(IDX_W), .OUT_W(OUT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .blk_start_i (blk_start_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_pwr_o   (out_pwr_o),
  .out_idx_o   (out_idx_o),
  .out_done_o  (out_done_o)
);

// File: tb/doppler_range_avg_tb.sv
module doppler_range_avg_tb;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               blk_start = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [15:0] in_re = '0;
  logic signed [15:0] in_im = '0;
  logic [5:0]         in_idx = '0;
  logic               in_last = 1'b0;
  logic               out_valid;
  logic               out_ready = 1'b0;
  logic [31:0]        out_pwr;
  logic [5:0]         out_idx;
  logic               out_done;

  int tests = 0;
  int fails = 0;
  longint exp_sum [64];

  // {re_base, re_per_bin, re_per_cell, im_base, im_per_bin, im_per_cell, reversed}
  localparam int PAT [5][7] = '{
    '{-3000,  100,   11,    500,     1,  -60, 0},
    '{-32768,   0,    0, -32768,     0,    0, 0},
    '{0,        0,    0,      0,     0,    0, 1},
    '{32767,    0,    0, -32768,     0,    0, 1},
    '{0,     1031, 4099,      7, -2311,  613, 1}
  };

  always #4 clk = ~clk;

  doppler_range_avg u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .blk_start_i (blk_start),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_re_i     (in_re),
    .in_im_i     (in_im),
    .in_idx_i    (in_idx),
    .in_last_i   (in_last),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_pwr_o   (out_pwr),
    .out_idx_o   (out_idx),
    .out_done_o  (out_done)
  );

  task automatic check(input logic ok, input string req, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // idle beat carrying junk: must be ignored (R9)
  task automatic junk_idle();
    @(negedge clk);
    in_valid = 1'b0; in_re = 16'sh7fff; in_im = -16'sd5; in_idx = 6'd9; in_last = 1'b1;
  endtask

  // send nr range cells of pattern p; model of sums is the bench's own (R1)
  task automatic fill(input int p, input int nr);
    for (int b = 0; b < 64; b++) exp_sum[b] = 0;
    for (int r = 0; r < nr; r++) begin
      for (int k = 0; k < 64; k++) begin
        int b;
        logic signed [15:0] vr, vi;
        b  = (PAT[p][6] != 0) ? 63 - k : k;
        vr = 16'(PAT[p][0] + PAT[p][1] * b + PAT[p][2] * r);
        vi = 16'(PAT[p][3] + PAT[p][4] * b + PAT[p][5] * r);
        exp_sum[b] += longint'(vr) * longint'(vr) + longint'(vi) * longint'(vi);
        if (k % 16 == 5) junk_idle();
        @(negedge clk);
        in_valid = 1'b1; in_re = vr; in_im = vi; in_idx = 6'(b); in_last = (k == 63);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // take all 64 beats; fill() leaves the bench at a negedge with the drain started
  task automatic drain(input string tag);
    out_ready = 1'b1;
    for (int beat = 0; beat < 64; beat++) begin
      longint e;
      e = (exp_sum[beat] >> 3) & 64'hFFFF_FFFF;
      check(out_valid && out_idx == 6'(beat), {tag, " R4 beat order"}, longint'(out_idx), beat);
      check(longint'(out_pwr) == e, {tag, " R2 averaged power"}, longint'(out_pwr), e);
      check(out_done == (beat == 63), {tag, " R5 done flag"}, longint'(out_done), longint'(beat == 63));
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(!out_valid && in_ready, {tag, " R4 back to accepting"}, longint'(out_valid), 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready && !out_done, "R8 reset state", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R8 after release", longint'(out_valid), 0);

    // table walk: back-to-back groups, max power then zeros checks R3 load
    for (int p = 0; p < 5; p++) begin
      fill(p, 8);
      drain($sformatf("pat%0d R1 R3", p));
    end

    // stall with junk input pending: R6, R9
    fill(0, 8);
    in_valid = 1'b1; in_re = 16'sh4000; in_idx = 6'd0; in_last = 1'b1;
    begin
      longint e0;
      e0 = (exp_sum[0] >> 3) & 64'hFFFF_FFFF;
      for (int s = 0; s < 5; s++) begin
        @(negedge clk);
        check(out_valid && !in_ready && out_idx == 6'd0 && longint'(out_pwr) == e0,
              "R6 stall hold", longint'(out_pwr), e0);
      end
    end
    in_valid = 1'b0; in_last = 1'b0;
    drain("R6 R9 after stall");

    // block start discards a partial group: R7
    fill(4, 3);
    blk_start = 1'b1;
    @(negedge clk);
    blk_start = 1'b0;
    fill(0, 8);
    drain("R7 realign");

    // block start abandons a drain: R7
    fill(1, 8);
    out_ready = 1'b1;
    repeat (5) @(negedge clk);
    out_ready = 1'b0; blk_start = 1'b1;
    @(negedge clk);
    blk_start = 1'b0;
    check(!out_valid && in_ready, "R7 abort drain", longint'(out_valid), 0);
    fill(4, 8);
    drain("R7 after abort");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule